// File: doc/BRIEF.md
# Masked Sticky Counter-Wrap Interrupt Unit

The block observes a bank of event counters and raises an interrupt when any enabled counter wraps from its maximum value back to zero. Each counter has its own bit in an interrupt vector; the bit is latched and held until software issues a soft clear, so a short-lived wrap is never missed. A single combined interrupt line is the OR of the vector presented at the output.

A 32-bit enable mask selects which counters may record an interrupt; only the low bits that correspond to real counters are used. A unit enable gates both outputs without disturbing the stored vector. The one-bit wrap flag of each counter sits in a triplicated register read through a majority vote, so a single upset in one copy does not create or drop an interrupt.

Top module: `ovf_irq_unit`

## Requirements
- R1: An active-low asynchronous reset clears the interrupt vector, the pending wrap flags and the stored previous counter values (to zero), so a counter that reads zero after reset does not count as a wrap even if it read all ones before reset.
- R2: A wrap of counter i is a cycle in which its input is zero while the value captured at the previous rising edge was all ones; any other transition (all ones to a non-zero value, non-zero to zero) records nothing.
- R3: A wrap is recorded only when mask bit i is 1 in the same cycle in which the counter input reads zero.
- R4: Mask bits 31 down to 24 (above the 24 counters) have no effect.
- R5: A recorded vector bit stays 1 through further counting until a soft clear.
- R6: Soft clear high at a rising edge sets every vector bit that has no new wrap pending to 0.
- R7: With the unit enable low, the vector output and the combined interrupt are 0; the stored vector is kept and keeps recording, and reappears when the enable returns high.
- R8: A wrap whose flag is pending at the same edge as a soft clear survives the clear; only older bits are removed.
- R9: The combined interrupt equals the OR of all bits of the vector output.
- R10: If the zero input of a wrap is sampled at rising edge k, vector bit i is 1 after edge k+1 and 0 after edge k; the pending flag between the two edges is held in three copies and read by majority vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable; low forces both outputs to 0 |
| soft_clr_i | input | 1 | Software clear of the interrupt vector |
| irq_mask_i | input | 32 | Per-counter interrupt enable, bit i for counter i; bits 31:24 unused |
| cnt_vals_i | input | 768 | Counter values, counter i in bits [32*i+31:32*i] |
| irq_vec_o | output | 24 | Sticky per-counter interrupt vector |
| irq_o | output | 1 | Combined interrupt |

## Verification
The soft clear and a new wrap can hit the vector at the same rising edge. The bench lines the two up deliberately by driving a masked counter to all ones and then zero, and raising the clear exactly one cycle later, when the wrap flag is pending; the vector must then hold only that counter's bit. Random traffic with a frequent all-ones/zero mix and rare clears also collides them, and a cycle-by-cycle bench model judges each outcome against the rule that the new wrap wins over the clear.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
  localparam int unsigned N_CNT_DEF  = 24;
  localparam int unsigned CNT_W_DEF  = 32;
  localparam int unsigned MASK_W_DEF = 32;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/ovf_wrap_detect.sv
module ovf_wrap_detect #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] val_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= val_i;
  end

  assign wrap_o = (&prev_q) & ~(|val_i);
endmodule

// File: rtl/tmr_bit.sv
module tmr_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import ovf_irq_pkg::*;

  logic [2:0] rep_q;

  // each copy reloads every cycle, so an upset lasts one cycle at most
  for (genvar r = 0; r < 3; r++) begin : g_rep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rep_q[r] <= 1'b0;
      else         rep_q[r] <= d_i;
    end
  end

  assign q_o = maj3(rep_q[0], rep_q[1], rep_q[2]);
endmodule

// File: rtl/ovf_irq_unit.sv
module ovf_irq_unit #(
  parameter int unsigned N_CNT  = ovf_irq_pkg::N_CNT_DEF,
  parameter int unsigned CNT_W  = ovf_irq_pkg::CNT_W_DEF,
  parameter int unsigned MASK_W = ovf_irq_pkg::MASK_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   soft_clr_i,
  input  logic [MASK_W-1:0]      irq_mask_i,
  input  logic [N_CNT*CNT_W-1:0] cnt_vals_i,
  output logic [N_CNT-1:0]       irq_vec_o,
  output logic                   irq_o
);
  localparam int unsigned RSV_W = MASK_W - N_CNT;

  logic [N_CNT-1:0] wrap_raw;
  logic [N_CNT-1:0] ovf_flag;
  logic [N_CNT-1:0] past_vec_q;
  logic [RSV_W-1:0] mask_rsv_unused;
  logic             unit_disabled;

  assign mask_rsv_unused = irq_mask_i[MASK_W-1:N_CNT];

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    ovf_wrap_detect #(.CNT_W(CNT_W)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (cnt_vals_i[i*CNT_W +: CNT_W]),
      .wrap_o (wrap_raw[i])
    );

    tmr_bit u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (wrap_raw[i] & irq_mask_i[i]),
      .q_o    (ovf_flag[i])
    );
  end

  // a pending flag wins over a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vec_q <= '0;
    else         past_vec_q <= (soft_clr_i ? '0 : past_vec_q) | ovf_flag;
  end

  assign unit_disabled = ~en_i;
  assign irq_vec_o     = unit_disabled ? '0 : past_vec_q;
  assign irq_o         = ~unit_disabled & (|past_vec_q);
endmodule

// File: rtl/ovf_irq_unit_chk.sv
module ovf_irq_unit_chk #(
  parameter int unsigned N_CNT  = 24,
  parameter int unsigned MASK_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              soft_clr_i,
  input logic [MASK_W-1:0] irq_mask_i,
  input logic [N_CNT-1:0]  irq_vec_o,
  input logic              irq_o
);
  // R7
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (irq_vec_o == '0) && !irq_o);

  // R9
  a_r9_irq_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o != '0));

  // R5
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(soft_clr_i))
      |-> ((irq_vec_o & $past(irq_vec_o)) == $past(irq_vec_o)));

  // R3
  a_r3_masked_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i))
      |-> ((irq_vec_o & ~$past(irq_vec_o) & ~$past(irq_mask_i[N_CNT-1:0], 2)) == '0));

  // R6
  a_r6_clear_drops_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(soft_clr_i))
      |-> ($countones(irq_vec_o) <= $countones($past(irq_mask_i[N_CNT-1:0], 2))));
endmodule

bind ovf_irq_unit ovf_irq_unit_chk #(.N_CNT(N_CNT), .MASK_W(MASK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .soft_clr_i (soft_clr_i),
  .irq_mask_i (irq_mask_i),
  .irq_vec_o  (irq_vec_o),
  .irq_o      (irq_o)
);

// File: tb/tb_ovf_irq_unit.sv
module tb_ovf_irq_unit;
  localparam int unsigned N      = 24;
  localparam int unsigned CW     = 32;
  localparam int unsigned MW     = 32;
  localparam int unsigned CLK_P  = 10;
  localparam logic [CW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          clr = 1'b0;
  logic [MW-1:0] mask = '0;
  logic [N*CW-1:0] cnt = '0;
  logic [N-1:0]  vec_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [CW-1:0] prev_m [N];
  logic [N-1:0]  ovf_m = '0;
  logic [N-1:0]  vec_m = '0;

  always #(CLK_P/2) clk = ~clk;

  ovf_irq_unit #(.N_CNT(N), .CNT_W(CW), .MASK_W(MW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .soft_clr_i(clr),
    .irq_mask_i(mask), .cnt_vals_i(cnt), .irq_vec_o(vec_o), .irq_o(irq_o)
  );

  function automatic logic [CW-1:0] pick();
    case ($urandom_range(0, 3))
      0:       return ONES;
      1:       return '0;
      2:       return ONES - 1;
      default: return $urandom;
    endcase
  endfunction

  task automatic model_edge();
    logic [N-1:0] nw;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prev_m[i] = '0;
      ovf_m = '0;
      vec_m = '0;
    end else begin
      for (int i = 0; i < N; i++)
        nw[i] = (prev_m[i] == ONES) && (cnt[i*CW +: CW] == '0) && mask[i];
      vec_m = (clr ? '0 : vec_m) | ovf_m;
      ovf_m = nw;
      for (int i = 0; i < N; i++) prev_m[i] = cnt[i*CW +: CW];
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] exp_v);
    checks++;
    if (vec_o !== exp_v || irq_o !== (|exp_v)) begin
      fails++;
      $display("FAIL %s vec=%h irq=%b expected vec=%h irq=%b", tag, vec_o, irq_o, exp_v, |exp_v);
    end
  endtask

  task automatic set_cnt(input int i, input logic [CW-1:0] v);
    cnt[i*CW +: CW] = v;
  endtask

  task automatic wrap(input int i);
    set_cnt(i, ONES); step();
    set_cnt(i, '0);   step();
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < N; i++) prev_m[i] = '0;
    @(negedge clk); step(); step();
    chk("R1 reset state", '0);
    rst_n = 1'b1;

    // R1: all ones before reset, zero after it is not a wrap
    mask = 32'h00FF_FFFF;
    set_cnt(5, ONES); step(); step();
    rst_n = 1'b0; set_cnt(5, '0); step();
    rst_n = 1'b1; step(); step(); step();
    chk("R1 prev cleared by reset", '0);

    // R2 R10: masked wrap on counter 3
    mask = 32'h0000_0008;
    wrap(3);
    chk("R10 not yet after zero edge", '0);
    step();
    chk("R10 R2 wrap recorded", 24'h000008);
    chk("R9 combined irq", 24'h000008);

    // R3: unmasked counter 7
    wrap(7); step(); step();
    chk("R3 unmasked wrap ignored", 24'h000008);

    // R2: non-wrap transitions on masked counter 4
    mask = 32'h0000_0018;
    set_cnt(4, ONES); step(); set_cnt(4, 32'd5); step();
    set_cnt(4, 32'h10); step(); set_cnt(4, '0); step(); step(); step();
    chk("R2 non-wrap transitions", 24'h000008);

    // R4: reserved mask bits only
    mask = 32'hFF00_0008;
    wrap(9); step(); step();
    chk("R4 reserved mask bits", 24'h000008);

    // R5: counter 3 keeps counting
    for (int k = 1; k < 6; k++) begin set_cnt(3, k); step(); end
    chk("R5 sticky", 24'h000008);

    // R7: disable hides, keeps recording
    mask = 32'h0000_1008;
    en = 1'b0; step();
    chk("R7 disabled outputs low", '0);
    wrap(12); step(); step();
    chk("R7 disabled still low", '0);
    en = 1'b1; @(posedge clk); model_edge(); #1;
    chk("R7 re-enabled shows vector", 24'h001008);
    @(negedge clk);

    // R6: soft clear
    clr = 1'b1; step(); clr = 1'b0; step();
    chk("R6 soft clear", '0);

    // R8: wrap pending at the clear edge survives
    mask = 32'h0000_0408;
    wrap(3); step(); step();
    chk("R8 setup", 24'h000008);
    wrap(10);
    clr = 1'b1; step(); clr = 1'b0;
    chk("R8 new wrap wins over clear", 24'h000400);
    step();
    chk("R8 stays after clear", 24'h000400);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) mask = $urandom;
      en  = ($urandom_range(0, 15) != 0);
      clr = ($urandom_range(0, 23) == 0);
      for (int i = 0; i < N; i++) set_cnt(i, pick());
      step();
      chk("R2 R3 R5 R6 R7 R8 R9 random", en ? vec_m : '0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule